// File: doc/BRIEF.md
# Multiplexed Converter Scan Controller

This block runs on a fast system clock and drives an external eight-input successive-approximation converter that has a latched channel address, an address strobe, a start strobe, an end-of-conversion flag and an output-enabled 8-bit data bus. It walks the channels selected by an enable mask in ascending order. For each channel it presents the address, pulses the address strobe, pulses start, waits for the conversion to finish, opens the data bus, samples the result and stores it in a per-channel result register. Host logic reads the stored values through a combinational read port.

Every converter timing constraint is held as a whole number of system clock cycles, set by parameters: address setup and hold around the strobe, both strobe widths, the bus access time after output-enable and the bus release time after it. The flag is synchronised before use. A flag that is still high from the previous conversion is never taken as completion. A conversion that does not finish in time is dropped: an error is flagged and the scan moves on.

Top module: `adc_scan_ctrl`

## Requirements
- R1: `adcAddr` carries the channel number, with bit 2 the most significant of the three address bits, so that value k selects input k. It is stable for at least ADDR_SETUP_CYC cycles before `adcAle` rises and for at least ADDR_HOLD_CYC cycles after it falls.
- R2: `adcAle` is high for exactly ALE_HIGH_CYC cycles per channel.
- R3: `adcStart` is high for exactly START_HIGH_CYC cycles and rises no earlier than ADDR_HOLD_CYC cycles after `adcAle` falls. At most one of `adcAle`, `adcStart` and `adcOe` is high in any cycle.
- R4: After a start pulse, completion is only a rise of `adcEoc` that follows a low level of `adcEoc`. A flag that stays high after start is not completion.
- R5: `adcOe` stays high for exactly OE_ACCESS_CYC cycles. The register of the current channel takes the value on `adcData` in the last of those cycles. `adcOe` is then low for at least OE_RELEASE_CYC cycles before the next `adcAle`.
- R6: While `scanEn` is high, the channels whose `chanMask` bit is 1 are converted in ascending order, starting from channel 0 when a scan starts and wrapping from the highest back to the lowest. Channels whose bit is 0 are never addressed. If the mask is all zero, no strobe is issued.
- R7: If completion is not seen within TIMEOUT_CYC cycles after the start pulse ends, `tmoErr` pulses for one cycle with `resChan` set to the channel. That channel's register is left unchanged and the scan moves on to the next enabled channel.
- R8: Each register write produces a one-cycle `resDone` pulse, in the first cycle with `adcOe` low, with `resChan` set to the written channel. `resDone` and `tmoErr` are never high together.
- R9: Reset clears all result registers to 0 and drives all three strobes, `resDone` and `tmoErr` low. `rdData` always shows the register selected by `rdIdx`.
- R10: When `scanEn` falls, the channel in progress is finished. The block then goes idle and issues no further strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| scanEn | input | 1 | Scan run request |
| chanMask | input | 8 | Per-channel enable, bit k enables channel k |
| adcAddr | output | 3 | Channel address to the converter |
| adcAle | output | 1 | Address latch strobe |
| adcStart | output | 1 | Conversion start strobe |
| adcOe | output | 1 | Converter data output enable |
| adcEoc | input | 1 | End-of-conversion flag from the converter |
| adcData | input | 8 | Converter data bus |
| rdIdx | input | 3 | Result register select |
| rdData | output | 8 | Selected result register |
| resDone | output | 1 | One-cycle pulse when a result is stored |
| resChan | output | 3 | Channel of the last store or timeout |
| tmoErr | output | 1 | One-cycle pulse when a conversion times out |

## Verification
The converter model keeps the flag high for several cycles after the start pulse ends and presents valid data only once the conversion is complete and the bus access time has passed. A controller that treats the stale high flag as completion, or that samples the bus too early, therefore stores the filler value 0xEE instead of the expected result. Sparse masks, a single-channel mask and the wrap back to the lowest channel expose an off-by-one or a missing wrap in the channel search, which shows up as a wrong channel order or a write to a disabled channel. Two stuck-flag cases check that a conversion that never finishes raises the error for the right channel and leaves that register untouched. A scan stopped in the middle of a channel must finish with exactly one stored result.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LATCH,
    ST_HOLD,
    ST_START,
    ST_WAIT_LO,
    ST_WAIT_HI,
    ST_READ,
    ST_GAP
  } scanState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic selNext;   // load next enabled channel
    logic selFirst;  // search from channel 0 instead of current+1
    logic capture;   // store bus value for current channel
    logic timeout;   // conversion abandoned
  } scanStrb_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_scan_pkg::*;
#(
  parameter int ADDR_SETUP_CYC = 3,
  parameter int ALE_HIGH_CYC   = 10,
  parameter int ADDR_HOLD_CYC  = 3,
  parameter int START_HIGH_CYC = 10,
  parameter int OE_ACCESS_CYC  = 13,
  parameter int OE_RELEASE_CYC = 13,
  parameter int TIMEOUT_CYC    = 6000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      scanEn,
  input  logic      anyEn,
  input  logic      eocSync,
  output scanStrb_t strb,
  output logic      adcAle,
  output logic      adcStart,
  output logic      adcOe
);

  localparam int MAXC = imax(imax(imax(ADDR_SETUP_CYC, ALE_HIGH_CYC), imax(ADDR_HOLD_CYC, START_HIGH_CYC)),
                             imax(imax(OE_ACCESS_CYC, OE_RELEASE_CYC), TIMEOUT_CYC));
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SETUP_LAST = CW'(ADDR_SETUP_CYC - 1);
  localparam logic [CW-1:0] ALE_LAST   = CW'(ALE_HIGH_CYC - 1);
  localparam logic [CW-1:0] HOLD_LAST  = CW'(ADDR_HOLD_CYC - 1);
  localparam logic [CW-1:0] START_LAST = CW'(START_HIGH_CYC - 1);
  localparam logic [CW-1:0] ACC_LAST   = CW'(OE_ACCESS_CYC - 1);
  localparam logic [CW-1:0] REL_LAST   = CW'(OE_RELEASE_CYC - 1);
  localparam logic [CW-1:0] TMO_LAST   = CW'(TIMEOUT_CYC - 1);

  scanState_t st, nxt;
  logic [CW-1:0] cnt;
  logic keepCnt;

  always_comb begin
    nxt     = st;
    strb    = '0;
    keepCnt = 1'b0;
    case (st)
      ST_IDLE: if (scanEn && anyEn) begin
        nxt = ST_SETUP;
        strb.selNext  = 1'b1;
        strb.selFirst = 1'b1;
      end
      ST_SETUP: if (cnt == SETUP_LAST) nxt = ST_LATCH;
      ST_LATCH: if (cnt == ALE_LAST)   nxt = ST_HOLD;
      ST_HOLD:  if (cnt == HOLD_LAST)  nxt = ST_START;
      ST_START: if (cnt == START_LAST) nxt = ST_WAIT_LO;
      ST_WAIT_LO: begin
        // a flag still high here belongs to the previous conversion
        if (!eocSync) begin
          nxt     = ST_WAIT_HI;
          keepCnt = 1'b1;
        end else if (cnt >= TMO_LAST) begin
          nxt = ST_GAP;
          strb.timeout = 1'b1;
        end
      end
      ST_WAIT_HI: begin
        if (eocSync) nxt = ST_READ;
        else if (cnt >= TMO_LAST) begin
          nxt = ST_GAP;
          strb.timeout = 1'b1;
        end
      end
      ST_READ: if (cnt == ACC_LAST) begin
        nxt = ST_GAP;
        strb.capture = 1'b1;
      end
      ST_GAP: if (cnt == REL_LAST) begin
        if (scanEn && anyEn) begin
          nxt = ST_SETUP;
          strb.selNext = 1'b1;
        end else begin
          nxt = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      st <= nxt;
      if (st == ST_IDLE || (nxt != st && !keepCnt)) cnt <= '0;
      else cnt <= cnt + 1'b1;
    end
  end

  assign adcAle   = (st == ST_LATCH);
  assign adcStart = (st == ST_START);
  assign adcOe    = (st == ST_READ);

endmodule

// File: rtl/adc_scan_dp.sv
module adc_scan_dp
  import adc_scan_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int NCH    = 2 ** ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  scanStrb_t         strb,
  input  logic [NCH-1:0]    chanMask,
  input  logic              adcEoc,
  input  logic [DATA_W-1:0] adcData,
  input  logic [ADDR_W-1:0] rdIdx,
  output logic              eocSync,
  output logic              anyEn,
  output logic [ADDR_W-1:0] adcAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              resDone,
  output logic [ADDR_W-1:0] resChan,
  output logic              tmoErr
);

  logic [1:0]        eocPipe;
  logic [ADDR_W-1:0] curChan, base, pick, probe;
  logic              found;
  logic [DATA_W-1:0] regOut [NCH];

  always_ff @(posedge clk) begin
    if (!rstN) eocPipe <= 2'b11;
    else       eocPipe <= {eocPipe[0], adcEoc};
  end
  assign eocSync = eocPipe[1];
  assign anyEn   = |chanMask;

  // first enabled channel at or after base, cyclic
  always_comb begin
    base  = strb.selFirst ? '0 : curChan + 1'b1;
    pick  = curChan;
    found = 1'b0;
    probe = '0;
    for (int i = 0; i < NCH; i++) begin
      probe = base + ADDR_W'(i);
      if (!found && chanMask[probe]) begin
        pick  = probe;
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curChan <= '0;
      resDone <= 1'b0;
      tmoErr  <= 1'b0;
      resChan <= '0;
    end else begin
      if (strb.selNext && found) curChan <= pick;
      resDone <= strb.capture;
      tmoErr  <= strb.timeout;
      if (strb.capture || strb.timeout) resChan <= curChan;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : gRes
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN) q <= '0;
      else if (strb.capture && curChan == ADDR_W'(g)) q <= adcData;
    end
    assign regOut[g] = q;
  end

  assign adcAddr = curChan;
  assign rdData  = regOut[rdIdx];

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int ADDR_W         = 3,
  parameter int DATA_W         = 8,
  parameter int ADDR_SETUP_CYC = 3,
  parameter int ALE_HIGH_CYC   = 10,
  parameter int ADDR_HOLD_CYC  = 3,
  parameter int START_HIGH_CYC = 10,
  parameter int OE_ACCESS_CYC  = 13,
  parameter int OE_RELEASE_CYC = 13,
  parameter int TIMEOUT_CYC    = 6000,
  localparam int NCH           = 2 ** ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              scanEn,
  input  logic [NCH-1:0]    chanMask,
  output logic [ADDR_W-1:0] adcAddr,
  output logic              adcAle,
  output logic              adcStart,
  output logic              adcOe,
  input  logic              adcEoc,
  input  logic [DATA_W-1:0] adcData,
  input  logic [ADDR_W-1:0] rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic              resDone,
  output logic [ADDR_W-1:0] resChan,
  output logic              tmoErr
);

  scanStrb_t strb;
  logic eocSync, anyEn;

  adc_scan_fsm #(
    .ADDR_SETUP_CYC(ADDR_SETUP_CYC), .ALE_HIGH_CYC(ALE_HIGH_CYC),
    .ADDR_HOLD_CYC(ADDR_HOLD_CYC), .START_HIGH_CYC(START_HIGH_CYC),
    .OE_ACCESS_CYC(OE_ACCESS_CYC), .OE_RELEASE_CYC(OE_RELEASE_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) uFsm (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .anyEn(anyEn), .eocSync(eocSync),
    .strb(strb), .adcAle(adcAle), .adcStart(adcStart), .adcOe(adcOe)
  );

  adc_scan_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCH(NCH)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .chanMask(chanMask),
    .adcEoc(adcEoc), .adcData(adcData), .rdIdx(rdIdx),
    .eocSync(eocSync), .anyEn(anyEn), .adcAddr(adcAddr), .rdData(rdData),
    .resDone(resDone), .resChan(resChan), .tmoErr(tmoErr)
  );

endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
  parameter int ADDR_W         = 3,
  parameter int ADDR_SETUP_CYC = 3,
  parameter int ALE_HIGH_CYC   = 10,
  parameter int ADDR_HOLD_CYC  = 3,
  parameter int START_HIGH_CYC = 10,
  parameter int OE_ACCESS_CYC  = 13,
  parameter int NCH            = 2 ** ADDR_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [NCH-1:0]    chanMask,
  input logic [ADDR_W-1:0] adcAddr,
  input logic              adcAle,
  input logic              adcStart,
  input logic              adcOe,
  input logic              adcEoc,
  input logic              resDone,
  input logic              tmoErr
);

  localparam int AGE_CAP = 1000000;

  logic aleQ, startQ, oeQ, eocLowSeen;
  logic [ADDR_W-1:0] addrQ;
  int aleLen, startLen, oeLen, addrAge;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aleQ <= 1'b0; startQ <= 1'b0; oeQ <= 1'b0; eocLowSeen <= 1'b0;
      addrQ <= '0; aleLen <= 0; startLen <= 0; oeLen <= 0; addrAge <= 0;
    end else begin
      aleQ   <= adcAle;
      startQ <= adcStart;
      oeQ    <= adcOe;
      addrQ  <= adcAddr;
      if (adcAle)   aleLen   <= aleQ   ? aleLen + 1   : 1;
      if (adcStart) startLen <= startQ ? startLen + 1 : 1;
      if (adcOe)    oeLen    <= oeQ    ? oeLen + 1    : 1;
      if (adcAddr != addrQ) addrAge <= 0;
      else if (addrAge < AGE_CAP) addrAge <= addrAge + 1;
      if (adcStart) eocLowSeen <= 1'b0;
      else if (!adcEoc) eocLowSeen <= 1'b1;
    end
  end

  assert_addr_setup_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcAle) |-> addrAge >= ADDR_SETUP_CYC - 1);
  assert_addr_window_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcStart) |-> addrAge >= ADDR_SETUP_CYC + ALE_HIGH_CYC + ADDR_HOLD_CYC - 1);
  assert_ale_width_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adcAle) |-> aleLen == ALE_HIGH_CYC);
  assert_start_width_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adcStart) |-> startLen == START_HIGH_CYC);
  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({adcAle, adcStart, adcOe}));
  assert_eoc_fall_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcOe) |-> eocLowSeen);
  assert_oe_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adcOe) |-> oeLen == OE_ACCESS_CYC);
  assert_mask_only_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcAle) |-> chanMask[adcAddr]);
  assert_tmo_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    tmoErr |=> !tmoErr);
  assert_done_after_oe_R8: assert property (@(posedge clk) disable iff (!rstN)
    resDone |-> $fell(adcOe));
  assert_done_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(resDone && tmoErr));

endmodule

bind adc_scan_ctrl adc_scan_chk #(
  .ADDR_W(ADDR_W), .ADDR_SETUP_CYC(ADDR_SETUP_CYC), .ALE_HIGH_CYC(ALE_HIGH_CYC),
  .ADDR_HOLD_CYC(ADDR_HOLD_CYC), .START_HIGH_CYC(START_HIGH_CYC),
  .OE_ACCESS_CYC(OE_ACCESS_CYC), .NCH(NCH)
) uChk (
  .clk(clk), .rstN(rstN), .chanMask(chanMask), .adcAddr(adcAddr),
  .adcAle(adcAle), .adcStart(adcStart), .adcOe(adcOe), .adcEoc(adcEoc),
  .resDone(resDone), .tmoErr(tmoErr)
);

// File: tb/sim_adc_scan_ctrl.sv
module sim_adc_scan_ctrl;

  localparam int SETUP = 3, ALEW = 10, HOLD = 3, STARTW = 10, ACC = 13, REL = 13, TMO = 400;
  localparam int MODEL_ACC = 12;  // converter bus valid after this many OE cycles
  localparam int CONV = 40;       // converter busy cycles
  // vector: {mask[19:12], seed[11:4], blank[3:0]}
  localparam logic [19:0] VECS [6] = '{
    20'hFF_00_0, 20'hA5_3C_6, 20'h80_5A_7, 20'h01_C3_2, 20'h7E_99_5, 20'h12_F0_4
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scanEn = 1'b0;
  logic [7:0] chanMask = '0;
  logic [2:0] adcAddr, resChan, rdIdx;
  logic adcAle, adcStart, adcOe, resDone, tmoErr;
  logic adcEoc;
  logic [7:0] adcData, rdData;

  always #10 clk = ~clk;

  adc_scan_ctrl #(
    .ADDR_SETUP_CYC(SETUP), .ALE_HIGH_CYC(ALEW), .ADDR_HOLD_CYC(HOLD),
    .START_HIGH_CYC(STARTW), .OE_ACCESS_CYC(ACC), .OE_RELEASE_CYC(REL), .TIMEOUT_CYC(TMO)
  ) u0 (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .chanMask(chanMask), .adcAddr(adcAddr),
    .adcAle(adcAle), .adcStart(adcStart), .adcOe(adcOe), .adcEoc(adcEoc), .adcData(adcData),
    .rdIdx(rdIdx), .rdData(rdData), .resDone(resDone), .resChan(resChan), .tmoErr(tmoErr)
  );

  int total = 0, bad = 0;
  logic [7:0] seedV = '0;
  int blankCyc = 0, stuckMode = 0;
  logic [2:0] stuckCh = '0;

  function automatic logic [7:0] mval(input logic [2:0] ch, input logic [7:0] s);
    return s ^ (8'(ch) * 8'h1D + 8'h31);
  endfunction

  // behavioural converter
  int mPh, mCnt, oeCnt;
  logic [2:0] mAddr;
  logic aleP, startP;
  always @(negedge clk) begin
    if (!rstN) begin
      adcEoc <= 1'b1; mPh <= 0; mCnt <= 0; oeCnt <= 0; mAddr <= '0; aleP <= 1'b0; startP <= 1'b0;
    end else begin
      aleP <= adcAle; startP <= adcStart;
      if (adcAle && !aleP) mAddr <= adcAddr;
      oeCnt <= adcOe ? oeCnt + 1 : 0;
      if (adcStart && !startP) begin mPh <= 1; mCnt <= 0; end
      else if (mPh == 1) begin
        if (adcStart) mCnt <= 0;
        else if (mCnt >= blankCyc) begin
          if (!(stuckMode == 1 && mAddr == stuckCh)) begin adcEoc <= 1'b0; mPh <= 2; mCnt <= 0; end
        end else mCnt <= mCnt + 1;
      end else if (mPh == 2) begin
        if (mCnt >= CONV) begin
          if (!(stuckMode == 2 && mAddr == stuckCh)) begin adcEoc <= 1'b1; mPh <= 3; end
        end else mCnt <= mCnt + 1;
      end
    end
  end
  assign adcData = (adcOe && mPh == 3 && oeCnt >= MODEL_ACC) ? mval(mAddr, seedV) : 8'hEE;

  // recorder and timing monitor
  int cyc = 0, nGot = 0, tmoCnt = 0, aleRises = 0;
  logic [2:0] got [32];
  logic [2:0] lastTmoChan = '0;
  logic prevAle = 0, prevStart = 0, prevOe = 0, prevDone = 0, prevTmo = 0;
  logic [2:0] prevAddr = '0;
  int addrChg = -1000, aleRise = -1000, aleFall = -1000, startRise = -1000, oeRise = -1000, oeFall = -1000;
  logic vR1 = 0, vR2 = 0, vR3 = 0, vR5 = 0, vR7 = 0, vR8 = 0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (adcAddr != prevAddr) begin
        if (prevAle || adcAle || cyc - aleFall <= HOLD) vR1 = 1;
        addrChg = cyc;
      end
      if (adcAle && !prevAle) begin
        aleRises++;
        if (cyc - addrChg < SETUP) vR1 = 1;
        if (cyc - oeFall < REL) vR5 = 1;
        aleRise = cyc;
      end
      if (!adcAle && prevAle) begin
        if (cyc - aleRise != ALEW) vR2 = 1;
        aleFall = cyc;
      end
      if (adcStart && !prevStart) begin
        if (cyc - aleFall < HOLD) vR3 = 1;
        startRise = cyc;
      end
      if (!adcStart && prevStart && cyc - startRise != STARTW) vR3 = 1;
      if (adcOe && !prevOe) oeRise = cyc;
      if (!adcOe && prevOe) begin
        if (cyc - oeRise != ACC) vR5 = 1;
        oeFall = cyc;
      end
      if ($countones({adcAle, adcStart, adcOe}) > 1) vR3 = 1;
      if (resDone) begin
        if (nGot < 32) got[nGot] = resChan;
        nGot++;
        if (prevDone || tmoErr || adcOe || !prevOe) vR8 = 1;
      end
      if (tmoErr) begin
        tmoCnt++;
        lastTmoChan = resChan;
        if (prevTmo) vR7 = 1;
      end
    end
    prevAle = adcAle; prevStart = adcStart; prevOe = adcOe;
    prevDone = resDone; prevTmo = tmoErr; prevAddr = adcAddr;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; scanEn = 0; stuckMode = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    nGot = 0; tmoCnt = 0; aleRises = 0;
    vR1 = 0; vR2 = 0; vR3 = 0; vR5 = 0; vR7 = 0; vR8 = 0;
  endtask

  task automatic readReg(input int ch, output logic [7:0] d);
    @(negedge clk);
    rdIdx = 3'(ch);
    #1 d = rdData;
  endtask

  task automatic waitGot(input int n, input string req);
    int guard = 0;
    while (nGot < n && guard < 30000) begin @(negedge clk); guard++; end
    chk(nGot >= n, req, nGot, n);
  endtask

  task automatic timingChecks(input string tag);
    chk(!vR1, "R1 address setup/hold", vR1, 0);
    chk(!vR2, "R2 latch strobe width", vR2, 0);
    chk(!vR3, "R3 start width/exclusive", vR3, 0);
    chk(!vR5, "R5 oe access/release", vR5, 0);
    chk(!vR8, "R8 done pulse", vR8, 0);
  endtask

  initial begin
    logic [7:0] d, m;
    logic [2:0] expList [8];
    int pc;
    rdIdx = '0;
    doReset();
    // R9: reset state
    @(negedge clk);
    chk(!adcAle && !adcStart && !adcOe, "R9 strobes low after reset", {adcAle, adcStart, adcOe}, 0);
    chk(!resDone && !tmoErr, "R9 flags low after reset", {resDone, tmoErr}, 0);
    for (int c = 0; c < 8; c++) begin
      readReg(c, d);
      chk(d == 8'h00, "R9 register cleared", d, 0);
    end

    // vector table
    for (int v = 0; v < 6; v++) begin
      doReset();
      m = VECS[v][19:12];
      seedV = VECS[v][11:4];
      blankCyc = int'(VECS[v][3:0]);
      chanMask = m;
      pc = 0;
      for (int c = 0; c < 8; c++) if (m[c]) begin expList[pc] = 3'(c); pc++; end
      @(negedge clk) scanEn = 1;
      waitGot(pc + 1, "R6 results arrive");
      scanEn = 0;
      repeat (400) @(negedge clk);
      for (int k = 0; k <= pc; k++)
        chk(got[k] == expList[k % pc], "R6 ascending order with wrap", got[k], expList[k % pc]);
      for (int c = 0; c < 8; c++) begin
        readReg(c, d);
        if (m[c]) chk(d == mval(3'(c), seedV), "R4 R5 stored result", d, mval(3'(c), seedV));
        else      chk(d == 8'h00, "R6 disabled channel untouched", d, 0);
      end
      chk(tmoCnt == 0, "R7 no spurious timeout", tmoCnt, 0);
      timingChecks("vec");
    end

    // R6: empty mask issues nothing
    doReset();
    chanMask = 8'h00;
    scanEn = 1;
    repeat (300) @(negedge clk);
    chk(aleRises == 0 && !adcStart && !adcOe, "R6 empty mask idle", aleRises, 0);
    scanEn = 0;

    // R7: flag never falls on channel 1
    doReset();
    chanMask = 8'h0B; seedV = 8'h44; blankCyc = 3; stuckMode = 1; stuckCh = 3'd1;
    scanEn = 1;
    waitGot(2, "R7 scan continues past stuck channel");
    scanEn = 0;
    repeat (600) @(negedge clk);
    chk(got[0] == 3'd0 && got[1] == 3'd3, "R7 order skips timed-out channel", {got[0], got[1]}, 6'o03);
    chk(tmoCnt >= 1 && lastTmoChan == 3'd1, "R7 timeout channel", lastTmoChan, 1);
    readReg(1, d);
    chk(d == 8'h00, "R7 timed-out register unchanged", d, 0);
    readReg(3, d);
    chk(d == mval(3'd3, seedV), "R7 next channel stored", d, mval(3'd3, seedV));
    chk(!vR7, "R7 timeout pulse one cycle", vR7, 0);

    // R7: flag falls but never rises on channel 3
    doReset();
    chanMask = 8'h0F; seedV = 8'h81; blankCyc = 1; stuckMode = 2; stuckCh = 3'd3;
    scanEn = 1;
    waitGot(4, "R7 results after stuck-low channel");
    scanEn = 0;
    repeat (600) @(negedge clk);
    chk(got[3] == 3'd0, "R7 wrap after timeout", got[3], 0);
    chk(tmoCnt >= 1 && lastTmoChan == 3'd3, "R7 stuck-low timeout channel", lastTmoChan, 3);
    readReg(3, d);
    chk(d == 8'h00, "R7 stuck-low register unchanged", d, 0);
    timingChecks("tmo");

    // R10: stop mid-channel
    doReset();
    chanMask = 8'hFF; seedV = 8'h27; blankCyc = 2;
    scanEn = 1;
    while (aleRises < 1) @(negedge clk);
    scanEn = 0;
    repeat (1500) @(negedge clk);
    chk(nGot == 1 && got[0] == 3'd0, "R10 current channel finished", nGot, 1);
    chk(aleRises == 1, "R10 no strobes after stop", aleRises, 1);
    readReg(0, d);
    chk(d == mval(3'd0, seedV), "R10 result stored", d, mval(3'd0, seedV));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule